// File: doc/BRIEF.md
# Trap and Exception Entry Sequencer

This block carries a 16-bit-opcode core from normal execution into an exception handler. The execute stage signals a trap cause: an unconditional software trap, an overflow trap, a failed bound check or a division by zero. Separately, the fetch stage presents each decoded opcode word so that reserved and unimplemented encodings can be caught. When a qualified cause is present and the block is idle, it accepts exactly one cause and forms its vector number. It snapshots the status word and hands the core a new status word with supervisor mode on and tracing off.

It then uses a word-wide request/acknowledge memory port for five transfers. It pushes a return address and the old status word onto the supervisor stack. It then reads the two-word handler address from the vector table. Finally it loads that address into the program counter and returns to idle. A `busy` output tells the core that an entry is in flight, and requests that arrive during that time are dropped.

Top module: `trap_entry_seq`

## Requirements
- R1: A cause is qualified only as follows. `exec_trap` alone qualifies. `exec_trapv` qualifies only with `ovf_flag`. `exec_chk` qualifies only with `chk_fail`. `exec_div` qualifies only with `div_zero`. An opcode qualifies only with `op_valid` and a word that is one of 0x4AFA, 0x4AFB, 0x4AFC or has bits 15..12 equal to 0xA or 0xF. Unqualified inputs start no entry: `busy` and `mem_req` stay 0.
- R2: When several qualified causes appear in one idle cycle, one is accepted by fixed priority: opcode check first, then divide by zero, then bound check, then overflow, then the software trap.
- R3: The vector numbers are: reserved opcode 4, divide by zero 5, bound check 6, overflow 7, line 0xA 10, line 0xF 11, and software trap 32 plus opcode bits 3..0.
- R4: In the cycle after acceptance, `sr_load` pulses for one cycle. With it, `sr_new` equals the accepted `sr_in` with bit 13 (supervisor) set and bit 15 (trace) cleared. The word pushed to the stack is the unmodified `sr_in`.
- R5: Three writes occur in order. The first writes the return address bits 15..0 at `ssp_in`-2. The second writes the return address bits ADDR_W-1..16, zero-extended, at `ssp_in`-4. The third writes the saved status word at `ssp_in`-6. Each acknowledged write lowers `ssp_out` by 2, so it ends at `ssp_in`-6.
- R6: The return address pushed is `next_pc` for the four execute-stage causes and `cur_pc` for the opcode-check causes.
- R7: Two reads follow the writes: the high word at vector×4, then the low word at vector×4+2. In the cycle after the second acknowledge, `pc_load` pulses and `pc_new` equals {high word bits ADDR_W-17..0, low word}.
- R8: `mem_req` (with `mem_we` high for writes) stays asserted with a stable address, direction and write data until `mem_ack` is sampled high. Each acknowledge completes one word.
- R9: `busy` is high from the cycle after acceptance until the final read is acknowledged, and it is low in the cycle where `pc_load` is high.
- R10: Requests that arrive while `busy` is high are ignored and start no later entry once they are removed.
- R11: Under reset, `busy`, `mem_req`, `sr_load` and `pc_load` are 0 and `ssp_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | `opcode` holds a fetched, decoded word |
| opcode | input | 16 | Opcode word (also supplies the software trap number) |
| exec_trap | input | 1 | Software trap instruction executing |
| exec_trapv | input | 1 | Overflow-trap instruction executing |
| ovf_flag | input | 1 | Overflow condition is set |
| exec_chk | input | 1 | Bound-check instruction executing |
| chk_fail | input | 1 | Bound check failed |
| exec_div | input | 1 | Divide instruction executing |
| div_zero | input | 1 | Divisor is zero |
| sr_in | input | 16 | Live status word |
| cur_pc | input | ADDR_W | Address of the current instruction |
| next_pc | input | ADDR_W | Address of the following instruction |
| ssp_in | input | ADDR_W | Supervisor stack pointer before entry |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Entry sequence in progress |
| sr_load | output | 1 | Load `sr_new` into the status register |
| sr_new | output | 16 | Status word for handler mode |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address (byte-addressed, even) |
| mem_wdata | output | 16 | Write data |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | ADDR_W | Handler address |
| ssp_out | output | ADDR_W | Supervisor stack pointer as it is being lowered |

## Verification
Some properties are checked on every cycle. The supervisor bit is set and the trace bit is clear whenever the new status word is offered. The memory request holds its address and data until acknowledged. Every acknowledged write lowers the stack pointer by two. Vector reads stay inside the table at even addresses. A falling `busy` coincides with the program-counter load, and that load follows an acknowledged read. Only the bench scenarios can show the rest. These are which cause wins among simultaneous requests, the vector number each cause yields, the order and contents of the three stacked words, the choice between the current and following instruction address, and that unqualified or late requests leave the block idle.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int WORD_W = 16;
   localparam int VEC_W  = 8;

   localparam logic [VEC_W-1:0] VEC_ILLEGAL   = 8'd4;
   localparam logic [VEC_W-1:0] VEC_DIVZERO   = 8'd5;
   localparam logic [VEC_W-1:0] VEC_BOUND     = 8'd6;
   localparam logic [VEC_W-1:0] VEC_OVERFLOW  = 8'd7;
   localparam logic [VEC_W-1:0] VEC_LINE_A    = 8'd10;
   localparam logic [VEC_W-1:0] VEC_LINE_F    = 8'd11;
   localparam logic [VEC_W-1:0] VEC_SWTRAP    = 8'd32;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_LO,
      ST_PUSH_HI,
      ST_PUSH_SR,
      ST_VEC_HI,
      ST_VEC_LO
   } seq_state_t;

   typedef struct packed {
      logic             hit;
      logic             use_cur;
      logic [VEC_W-1:0] vec;
   } cause_t;
endpackage

// File: rtl/trap_cause_sel.sv
module trap_cause_sel
   import trap_pkg::*;
#(
   parameter int ILL_BASE = 16'h4AFA,
   parameter int ILL_NUM  = 3
)(
   input  logic              op_valid,
   input  logic [WORD_W-1:0] opcode,
   input  logic              exec_trap,
   input  logic              exec_trapv,
   input  logic              ovf_flag,
   input  logic              exec_chk,
   input  logic              chk_fail,
   input  logic              exec_div,
   input  logic              div_zero,
   output cause_t            sel
);
   localparam logic [3:0] LINE_A = 4'hA;
   localparam logic [3:0] LINE_F = 4'hF;

   if (ILL_NUM < 1 || ILL_BASE + ILL_NUM > 65536) begin : g_bad_ill
      $error("trap_cause_sel: reserved opcode range out of bounds");
   end

   logic [ILL_NUM-1:0] ill_hit;

   for (genvar g = 0; g < ILL_NUM; g++) begin : g_ill
      assign ill_hit[g] = (opcode == WORD_W'(ILL_BASE + g));
   end

   always_comb begin
      sel = '0;
      if (op_valid && |ill_hit) begin
         sel = '{hit: 1'b1, use_cur: 1'b1, vec: VEC_ILLEGAL};
      end else if (op_valid && opcode[15:12] == LINE_A) begin
         sel = '{hit: 1'b1, use_cur: 1'b1, vec: VEC_LINE_A};
      end else if (op_valid && opcode[15:12] == LINE_F) begin
         sel = '{hit: 1'b1, use_cur: 1'b1, vec: VEC_LINE_F};
      end else if (exec_div && div_zero) begin
         sel = '{hit: 1'b1, use_cur: 1'b0, vec: VEC_DIVZERO};
      end else if (exec_chk && chk_fail) begin
         sel = '{hit: 1'b1, use_cur: 1'b0, vec: VEC_BOUND};
      end else if (exec_trapv && ovf_flag) begin
         sel = '{hit: 1'b1, use_cur: 1'b0, vec: VEC_OVERFLOW};
      end else if (exec_trap) begin
         sel = '{hit: 1'b1, use_cur: 1'b0,
                 vec: VEC_SWTRAP + VEC_W'(opcode[3:0])};
      end
   end
endmodule

// File: rtl/trap_entry_fsm.sv
module trap_entry_fsm
   import trap_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int S_BIT  = 13,
   parameter int T_BIT  = 15
)(
   input  logic              clk,
   input  logic              rst_n,
   input  cause_t            cause,
   input  logic [WORD_W-1:0] sr_in,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [ADDR_W-1:0] next_pc,
   input  logic [ADDR_W-1:0] ssp_in,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              busy,
   output logic              sr_load,
   output logic [WORD_W-1:0] sr_new,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_new,
   output logic [ADDR_W-1:0] ssp_out
);
   localparam int HI_W = ADDR_W - WORD_W;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

   if (ADDR_W <= WORD_W || ADDR_W > 2 * WORD_W) begin : g_bad_addr
      $error("trap_entry_fsm: ADDR_W must lie in 17..32");
   end
   if (S_BIT == T_BIT || S_BIT >= WORD_W || T_BIT >= WORD_W) begin : g_bad_bits
      $error("trap_entry_fsm: status bit positions invalid");
   end

   seq_state_t        state;
   logic [WORD_W-1:0] saved_sr;
   logic [ADDR_W-1:0] stk_pc;
   logic [ADDR_W-1:0] sp;
   logic [VEC_W-1:0]  vec_r;
   logic [HI_W-1:0]   hi_bits;
   logic [WORD_W-1:0] pc_hi_word;
   logic [ADDR_W-1:0] vec_addr;
   logic              pushing;

   always_comb begin
      pc_hi_word = '0;
      pc_hi_word[HI_W-1:0] = stk_pc[ADDR_W-1:WORD_W];
   end

   assign vec_addr = ADDR_W'({vec_r, 2'b00});
   assign pushing  = (state == ST_PUSH_LO) || (state == ST_PUSH_HI) ||
                     (state == ST_PUSH_SR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         saved_sr <= '0;
         stk_pc   <= '0;
         sp       <= '0;
         vec_r    <= '0;
         hi_bits  <= '0;
         sr_new   <= '0;
         sr_load  <= 1'b0;
         pc_new   <= '0;
         pc_load  <= 1'b0;
      end else begin
         sr_load <= 1'b0;
         pc_load <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cause.hit) begin
                  saved_sr      <= sr_in;
                  sr_new        <= sr_in;
                  sr_new[S_BIT] <= 1'b1;
                  sr_new[T_BIT] <= 1'b0;
                  sr_load       <= 1'b1;
                  stk_pc        <= cause.use_cur ? cur_pc : next_pc;
                  vec_r         <= cause.vec;
                  sp            <= ssp_in;
                  state         <= ST_PUSH_LO;
               end
            end
            ST_PUSH_LO: if (mem_ack) begin
               sp    <= sp - STEP;
               state <= ST_PUSH_HI;
            end
            ST_PUSH_HI: if (mem_ack) begin
               sp    <= sp - STEP;
               state <= ST_PUSH_SR;
            end
            ST_PUSH_SR: if (mem_ack) begin
               sp    <= sp - STEP;
               state <= ST_VEC_HI;
            end
            ST_VEC_HI: if (mem_ack) begin
               hi_bits <= mem_rdata[HI_W-1:0];
               state   <= ST_VEC_LO;
            end
            ST_VEC_LO: if (mem_ack) begin
               pc_new  <= {hi_bits, mem_rdata};
               pc_load <= 1'b1;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_wdata = '0;
      mem_addr  = sp - STEP;
      case (state)
         ST_PUSH_LO: mem_wdata = stk_pc[WORD_W-1:0];
         ST_PUSH_HI: mem_wdata = pc_hi_word;
         ST_PUSH_SR: mem_wdata = saved_sr;
         ST_VEC_HI:  mem_addr  = vec_addr;
         ST_VEC_LO:  mem_addr  = vec_addr + STEP;
         default:    mem_addr  = sp - STEP;
      endcase
   end

   assign busy    = (state != ST_IDLE);
   assign mem_req = busy;
   assign mem_we  = pushing;
   assign ssp_out = sp;
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
   import trap_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int S_BIT    = 13,
   parameter int T_BIT    = 15,
   parameter int ILL_BASE = 16'h4AFA,
   parameter int ILL_NUM  = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [WORD_W-1:0] opcode,
   input  logic              exec_trap,
   input  logic              exec_trapv,
   input  logic              ovf_flag,
   input  logic              exec_chk,
   input  logic              chk_fail,
   input  logic              exec_div,
   input  logic              div_zero,
   input  logic [WORD_W-1:0] sr_in,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [ADDR_W-1:0] next_pc,
   input  logic [ADDR_W-1:0] ssp_in,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              busy,
   output logic              sr_load,
   output logic [WORD_W-1:0] sr_new,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_new,
   output logic [ADDR_W-1:0] ssp_out
);
   cause_t cause;

   trap_cause_sel #(
      .ILL_BASE (ILL_BASE),
      .ILL_NUM  (ILL_NUM)
   ) u_sel (
      .op_valid   (op_valid),
      .opcode     (opcode),
      .exec_trap  (exec_trap),
      .exec_trapv (exec_trapv),
      .ovf_flag   (ovf_flag),
      .exec_chk   (exec_chk),
      .chk_fail   (chk_fail),
      .exec_div   (exec_div),
      .div_zero   (div_zero),
      .sel        (cause)
   );

   trap_entry_fsm #(
      .ADDR_W (ADDR_W),
      .S_BIT  (S_BIT),
      .T_BIT  (T_BIT)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cause     (cause),
      .sr_in     (sr_in),
      .cur_pc    (cur_pc),
      .next_pc   (next_pc),
      .ssp_in    (ssp_in),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .sr_load   (sr_load),
      .sr_new    (sr_new),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .pc_load   (pc_load),
      .pc_new    (pc_new),
      .ssp_out   (ssp_out)
   );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
   parameter int ADDR_W = 24,
   parameter int S_BIT  = 13,
   parameter int T_BIT  = 15
)(
   input logic              clk,
   input logic              rst_n,
   input logic              mem_ack,
   input logic              busy,
   input logic              sr_load,
   input logic [15:0]       sr_new,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [15:0]       mem_wdata,
   input logic              pc_load,
   input logic [ADDR_W-1:0] ssp_out
);
   // R4: handler status word has supervisor on, trace off
   a_r4_sr_mode: assert property (@(posedge clk) disable iff (!rst_n)
      sr_load |-> (sr_new[S_BIT] && !sr_new[T_BIT]));

   // R4: status load coincides with the start of busy
   a_r4_sr_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      sr_load |-> $rose(busy));

   // R5: each acknowledged write lowers the stack pointer by one word
   a_r5_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (ssp_out == $past(ssp_out) - ADDR_W'(2)));

   // R7: vector reads stay in the table at even addresses
   a_r7_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr < ADDR_W'(1024) && !mem_addr[0]));

   // R7: program counter load follows an acknowledged read
   a_r7_load_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> $past(mem_req && !mem_we && mem_ack));

   // R8: request holds until acknowledged
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

   // R9: busy ends exactly when the program counter is loaded
   a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> pc_load);

   a_r9_idle_at_load: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> !busy);
endmodule

bind trap_entry_seq trap_entry_chk #(
   .ADDR_W (ADDR_W),
   .S_BIT  (S_BIT),
   .T_BIT  (T_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_ack   (mem_ack),
   .busy      (busy),
   .sr_load   (sr_load),
   .sr_new    (sr_new),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .pc_load   (pc_load),
   .ssp_out   (ssp_out)
);

// File: tb/sim_trap_entry_seq.sv
`timescale 1ns/1ps
module sim_trap_entry_seq;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [15:0]   opcode = '0;
   logic          exec_trap = 1'b0, exec_trapv = 1'b0, ovf_flag = 1'b0;
   logic          exec_chk = 1'b0, chk_fail = 1'b0, exec_div = 1'b0, div_zero = 1'b0;
   logic [15:0]   sr_in = '0;
   logic [AW-1:0] cur_pc = '0, next_pc = '0, ssp_in = '0;
   logic          mem_ack = 1'b0;
   logic [15:0]   mem_rdata = '0;
   logic          busy, sr_load, mem_req, mem_we, pc_load;
   logic [15:0]   sr_new, mem_wdata;
   logic [AW-1:0] mem_addr, pc_new, ssp_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   trap_entry_seq #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .exec_trap(exec_trap), .exec_trapv(exec_trapv), .ovf_flag(ovf_flag),
      .exec_chk(exec_chk), .chk_fail(chk_fail), .exec_div(exec_div),
      .div_zero(div_zero), .sr_in(sr_in), .cur_pc(cur_pc), .next_pc(next_pc),
      .ssp_in(ssp_in), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
      .sr_load(sr_load), .sr_new(sr_new), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_load(pc_load),
      .pc_new(pc_new), .ssp_out(ssp_out)
   );

   // request bits: {trap, trapv, ovf, chk, chk_fail, div, div_zero}
   typedef struct packed {
      logic [6:0]  reqs;
      logic        opv;
      logic [15:0] op;
      logic [7:0]  vec;
      logic        use_cur;
   } tvec_t;

   localparam int NV = 15;
   localparam tvec_t TBL [NV] = '{
      '{7'b0000000, 1'b1, 16'h4AFA, 8'd4,  1'b1},   // R3 reserved
      '{7'b0000000, 1'b1, 16'h4AFB, 8'd4,  1'b1},
      '{7'b0000000, 1'b1, 16'h4AFC, 8'd4,  1'b1},
      '{7'b0000000, 1'b1, 16'hA123, 8'd10, 1'b1},   // R3 line A
      '{7'b0000000, 1'b1, 16'hF000, 8'd11, 1'b1},   // R3 line F
      '{7'b0000011, 1'b0, 16'h81C0, 8'd5,  1'b0},
      '{7'b0001100, 1'b0, 16'h4180, 8'd6,  1'b0},
      '{7'b0110000, 1'b0, 16'h4E76, 8'd7,  1'b0},
      '{7'b1000000, 1'b0, 16'h4E4F, 8'd47, 1'b0},
      '{7'b1000000, 1'b0, 16'h4E40, 8'd32, 1'b0},
      '{7'b1111111, 1'b1, 16'h4AFC, 8'd4,  1'b1},   // R2 all
      '{7'b1001111, 1'b0, 16'h4E41, 8'd5,  1'b0},   // R2
      '{7'b1111100, 1'b0, 16'h4E42, 8'd6,  1'b0},   // R2
      '{7'b1110000, 1'b0, 16'h4E43, 8'd7,  1'b0},   // R2
      '{7'b1101010, 1'b0, 16'h4E45, 8'd37, 1'b0}    // R1 unqualified ignored
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic drive_reqs(input logic [6:0] r, input logic opv, input logic [15:0] op);
      {exec_trap, exec_trapv, ovf_flag, exec_chk, chk_fail, exec_div, div_zero} = r;
      op_valid = opv;
      opcode   = op;
   endtask

   task automatic run_entry(input tvec_t t, input int seed, input bit noise);
      logic [15:0]   sr;
      logic [AW-1:0] cpc, npc, ssp, spc, va, exp_pc;
      logic [15:0]   exp_sr;
      sr  = 16'h8000 | 16'(seed * 16'h0111) | ((seed % 2 == 0) ? 16'h2000 : 16'h0000);
      sr[13] = (seed % 2 == 0);
      cpc = AW'(24'h0A1230 + seed * 16);
      npc = cpc + AW'(2 + 2 * (seed % 3));
      ssp = AW'(24'h00F000 - seed * 32);
      spc = t.use_cur ? cpc : npc;
      va  = AW'({t.vec, 2'b00});
      exp_pc = {va[7:0], (va[15:0] + 16'd2) ^ 16'h5A00};
      exp_sr = (sr | 16'h2000) & 16'h7FFF;
      sr_in = sr; cur_pc = cpc; next_pc = npc; ssp_in = ssp;
      drive_reqs(t.reqs, t.opv, t.op);
      @(posedge clk);
      @(negedge clk);
      drive_reqs(7'b0, 1'b0, 16'h0000);
      sr_in = ~sr;
      check(busy === 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
      check(sr_load === 1'b1 && sr_new === exp_sr, "R4 sr_new", 32'(sr_new), 32'(exp_sr));
      for (int k = 0; k < 5; k++) begin
         int guard = 0;
         while (mem_req !== 1'b1 && guard < 20) begin
            @(negedge clk);
            guard++;
         end
         check(mem_req === 1'b1, "R8 request present", 32'(mem_req), 32'd1);
         if (noise && k == 1) begin
            exec_div = 1'b1; div_zero = 1'b1; exec_trap = 1'b1;
         end
         if (noise && k == 4) drive_reqs(7'b0, 1'b0, 16'h0000);
         for (int d = 0; d < (seed + k) % 3; d++) @(negedge clk);
         case (k)
            0: check(mem_we === 1'b1 && mem_addr === ssp - 2 && mem_wdata === spc[15:0],
                     "R6 push pc low", {8'h0, mem_addr} ^ 32'(mem_wdata), {8'h0, ssp - AW'(2)} ^ 32'(spc[15:0]));
            1: check(mem_we === 1'b1 && mem_addr === ssp - 4 && mem_wdata === {8'h00, spc[23:16]},
                     "R5 push pc high", {8'h0, mem_addr} ^ 32'(mem_wdata), {8'h0, ssp - AW'(4)} ^ 32'({8'h00, spc[23:16]}));
            2: check(mem_we === 1'b1 && mem_addr === ssp - 6 && mem_wdata === sr,
                     "R4 R5 push saved sr", 32'(mem_wdata), 32'(sr));
            3: check(mem_we === 1'b0 && mem_addr === va,
                     "R3 R7 vector high read", 32'(mem_addr), 32'(va));
            default: check(mem_we === 1'b0 && mem_addr === va + 2,
                     "R7 vector low read", 32'(mem_addr), 32'(va + AW'(2)));
         endcase
         mem_rdata = mem_addr[15:0] ^ 16'h5A00;
         mem_ack = 1'b1;
         @(negedge clk);
         mem_ack = 1'b0;
      end
      check(pc_load === 1'b1 && pc_new === exp_pc, "R7 pc_new", 32'(pc_new), 32'(exp_pc));
      check(busy === 1'b0, "R9 busy low at load", 32'(busy), 32'd0);
      check(ssp_out === ssp - 6, "R5 final ssp", 32'(ssp_out), 32'(ssp - AW'(6)));
      @(negedge clk);
      check(busy === 1'b0 && mem_req === 1'b0, "R10 R1 stays idle", 32'(busy), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check(busy === 1'b0 && mem_req === 1'b0, "R11 reset idle", 32'(busy), 32'd0);
      check(sr_load === 1'b0 && pc_load === 1'b0, "R11 reset strobes", 32'(pc_load), 32'd0);
      check(ssp_out === '0, "R11 reset ssp", 32'(ssp_out), 32'd0);
      drive_reqs(7'b1111111, 1'b1, 16'h4AFC);
      @(negedge clk);
      check(busy === 1'b0, "R11 requests held in reset", 32'(busy), 32'd0);
      drive_reqs(7'b0, 1'b0, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_entry(TBL[i], i, 1'b0);

      // R1: unqualified requests start nothing
      drive_reqs(7'b0101010, 1'b1, 16'h4E71);
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && mem_req === 1'b0, "R1 unqualified no entry", 32'(busy), 32'd0);
      drive_reqs(7'b0000000, 1'b1, 16'h4AFD);
      repeat (2) @(negedge clk);
      check(busy === 1'b0 && mem_req === 1'b0, "R1 opcode 4AFD legal", 32'(busy), 32'd0);
      drive_reqs(7'b0000000, 1'b0, 16'hF000);
      repeat (2) @(negedge clk);
      check(busy === 1'b0, "R1 line F without op_valid", 32'(busy), 32'd0);
      drive_reqs(7'b0, 1'b0, 16'h0000);
      @(negedge clk);

      // R10: requests during busy ignored
      run_entry('{7'b0001100, 1'b0, 16'h4180, 8'd6, 1'b0}, 5, 1'b1);
      run_entry('{7'b1000000, 1'b0, 16'h4E4A, 8'd42, 1'b0}, 7, 1'b1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule